// File: doc/BRIEF.md
# Power-Up Mode Selector and Start-Up Gate

This block decides what a device does once its reset pin is let go. It picks the control interface type. The default is a two-wire bus. The first falling edge on the shared address/chip-select pin switches the interface to a four-wire serial bus, and that choice holds until the next reset. It also picks between stand-alone operation and register-driven operation. Finally, it releases the device start-up sequence with a single-cycle pulse.

Start-up is gated in two ways. The first is a fixed wait after reset, counted in ticks of a slow timing input (a 1 kHz tick with ten ticks by default, which gives about 10 ms). The second applies only while register-driven operation is selected: a power-down bit from the configuration register at address 07h can hold start-up off. That bit can be written before the wait ends, so software can configure the device before it starts. The bit can also take the device back down after start-up. Clearing it later restarts the device at once, without a second wait.

Top module: `pwrup_seq`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, spi_mode, ctl_mode, running and start_pulse are all 0.
- R2: If the shared pin stays static after reset, whether it is held high or low, spi_mode stays 0 (two-wire interface).
- R3: A high-to-low transition on sel_pin sets spi_mode to 1 within three clock edges. It then stays 1 through any further pin activity until rst_n goes low.
- R4: Before WAIT_TICKS tick pulses have been counted since reset, running and start_pulse stay 0.
- R5: In stand-alone mode (cfg_cpen = 0), start_pulse is high for exactly one cycle on the edge after the WAIT_TICKS-th tick is sampled. running then stays 1.
- R6: ctl_mode is 0 after reset and copies cfg_cpen (bit 1 of register 07h) one clock edge later. The bit may change at any time.
- R7: If ctl_mode is 1 and cfg_pdn (bit 0 of register 07h) is 1, no start-up happens even after the wait expires. The pulse comes on the edge after cfg_pdn is seen at 0.
- R8: After start-up in control-port mode, setting cfg_pdn clears running. Clearing cfg_pdn again gives a new single-cycle start_pulse without any further ticks.
- R9: In stand-alone mode, cfg_pdn has no effect on running or start_pulse.
- R10: Asserting rst_n low clears the wait count. After release, a full WAIT_TICKS ticks are needed again before start-up.
- R11: start_pulse is never high in two consecutive cycles, and it is high only in a cycle where running is also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (device reset pin) |
| tick | input | 1 | One-cycle timing pulse, nominally 1 kHz |
| sel_pin | input | 1 | Shared address/chip-select pin, asynchronous |
| cfg_cpen | input | 1 | Control-port enable bit from register 07h |
| cfg_pdn | input | 1 | Power-down bit from register 07h |
| spi_mode | output | 1 | 1 once the four-wire serial interface is latched |
| ctl_mode | output | 1 | 1 while register-driven operation is selected |
| running | output | 1 | 1 while start-up is released |
| start_pulse | output | 1 | One-cycle start-up begin strobe |

## Verification
A wrong wait count shows up as start_pulse arriving one tick early or late, so the bench checks just before and just after the boundary tick. A false power-down decision shows as running being high while the power-down bit is set in control-port mode, or as a missing pulse within two cycles of clearing the bit. A corrupted interface latch or edge detector shows within three edges of a pin fall, or as spi_mode appearing when the pin is tied low. Each of these is sampled within a few clock cycles of its cause.

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int WAIT_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sel_pin,
  input  logic cfg_cpen,
  input  logic cfg_pdn,
  output logic spi_mode,
  output logic ctl_mode,
  output logic running,
  output logic start_pulse
);
  localparam int CW = $clog2(WAIT_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_TICKS);

  logic [2:0]    pin_sh;
  logic [CW-1:0] wait_cnt;
  logic          wait_done;
  logic          pin_fall;
  logic          go;

  assign pin_fall  = pin_sh[2] & ~pin_sh[1];
  assign wait_done = (wait_cnt == LIMIT);
  assign go        = wait_done & ~(ctl_mode & cfg_pdn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sh   <= '0;
      spi_mode <= 1'b0;
    end else begin
      pin_sh <= {pin_sh[1:0], sel_pin};
      if (pin_fall) spi_mode <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wait_cnt <= '0;
    else if (tick && !wait_done)
      wait_cnt <= wait_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_mode    <= 1'b0;
      running     <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      ctl_mode    <= cfg_cpen;
      running     <= go;
      start_pulse <= go & ~running;
    end
  end
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_pdn,
  input logic spi_mode,
  input logic ctl_mode,
  input logic running,
  input logic start_pulse,
  input logic wait_done
);
  a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  a_r11_pulse_with_run: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> running);
  a_r3_spi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode);
  a_r4_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_done |=> !running);
  a_r7_pdn_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode && cfg_pdn) |=> !running);
endmodule

bind pwrup_seq pwrup_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pdn(cfg_pdn), .spi_mode(spi_mode),
  .ctl_mode(ctl_mode), .running(running), .start_pulse(start_pulse),
  .wait_done(wait_done)
);

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic sel_pin = 1'b1;
  logic cfg_cpen = 1'b0;
  logic cfg_pdn = 1'b0;
  logic spi_mode, ctl_mode, running, start_pulse;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit prev_pulse = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrup_seq #(.WAIT_TICKS(NT)) i_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel_pin(sel_pin),
    .cfg_cpen(cfg_cpen), .cfg_pdn(cfg_pdn), .spi_mode(spi_mode),
    .ctl_mode(ctl_mode), .running(running), .start_pulse(start_pulse)
  );

  always @(negedge clk) begin
    if (rst_n && start_pulse) pulses++;
    if (rst_n && start_pulse && prev_pulse) begin
      total++; bad++;
      $display("FAIL R11 start_pulse high two cycles: got 1 expected 0");
    end
    prev_pulse = start_pulse;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_cpen = 1'b0; cfg_pdn = 1'b0; tick = 1'b0;
    cycles(3);
    check("R1 spi_mode in reset", spi_mode, 0);
    check("R1 running in reset", running, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pulses = 0;
    check("R1 ctl_mode after reset", ctl_mode, 0);
    check("R1 start_pulse after reset", start_pulse, 0);
  endtask

  task automatic t_standalone();
    do_reset();
    for (int i = 0; i < NT - 1; i++) do_tick();
    cycles(3);
    check("R4 running before wait", running, 0);
    check("R4 pulses before wait", pulses, 0);
    do_tick();
    cycles(2);
    check("R5 one pulse after wait", pulses, 1);
    check("R5 running after wait", running, 1);
    cfg_pdn = 1'b1;
    cycles(4);
    check("R9 pdn ignored stand-alone running", running, 1);
    check("R9 pdn ignored stand-alone pulses", pulses, 1);
    check("R2 spi_mode with pin high", spi_mode, 0);
    cfg_pdn = 1'b0;
  endtask

  task automatic t_spi();
    sel_pin = 1'b0;
    do_reset();
    cycles(5);
    check("R2 spi_mode with pin low", spi_mode, 0);
    sel_pin = 1'b1;
    cycles(5);
    check("R2 spi_mode after rise", spi_mode, 0);
    sel_pin = 1'b0;
    cycles(3);
    check("R3 spi latched after fall", spi_mode, 1);
    sel_pin = 1'b1; cycles(3); sel_pin = 1'b0; cycles(3); sel_pin = 1'b1; cycles(3);
    check("R3 spi stays latched", spi_mode, 1);
    do_reset();
    check("R3 spi cleared by reset", spi_mode, 0);
  endtask

  task automatic t_ctl();
    do_reset();
    cfg_cpen = 1'b1; cfg_pdn = 1'b1;
    cycles(1);
    check("R6 ctl_mode follows enable", ctl_mode, 1);
    for (int i = 0; i < NT + 2; i++) do_tick();
    cycles(3);
    check("R7 held by pdn running", running, 0);
    check("R7 held by pdn pulses", pulses, 0);
    cfg_pdn = 1'b0;
    cycles(1);
    check("R7 pulse after pdn clear", start_pulse, 1);
    cycles(2);
    check("R7 single pulse", pulses, 1);
    check("R7 running", running, 1);
    cfg_pdn = 1'b1;
    cycles(2);
    check("R8 running drops on pdn", running, 0);
    cfg_pdn = 1'b0;
    cycles(3);
    check("R8 restart pulse no wait", pulses, 2);
    check("R8 running again", running, 1);
    cfg_cpen = 1'b0;
    cycles(1);
    check("R6 ctl_mode back to stand-alone", ctl_mode, 0);
  endtask

  task automatic t_reset_mid();
    do_reset();
    do_tick(); do_tick();
    do_reset();
    for (int i = 0; i < NT - 1; i++) do_tick();
    cycles(3);
    check("R10 wait restarted", running, 0);
    do_tick();
    cycles(2);
    check("R10 start after full wait", running, 1);
    check("R10 pulse count", pulses, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired: actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_standalone();
    t_spi();
    sel_pin = 1'b1;
    t_ctl();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule